// File: doc/BRIEF.md
# Hub-Cycle Slot Scheduler for a Shared Memory

This block decides, once per memory slot, which of a set of requester ports may use a single external memory. Time is cut into hub cycles. Each hub cycle holds two slots of `SLOT_LEN` clocks, and each slot carries one 16-bit access. Port 0 is the privileged port. The first slot of every hub cycle belongs to port 0. The second slot is shared: a round-robin rotation among ports 1 to N-1 uses it, and memory refresh uses it when the display is in blanking or when a refresh has waited too long.

A mode input chooses between two policies for the first slot. In dedicated mode that slot is reserved for port 0 and stays idle when port 0 has no request. In priority mode, if port 0 has no request, the first slot goes to the rotation instead. Port 0 can also ask for a 32-bit access, which takes two slots. When nothing else is pending, both halves land inside one hub cycle.

Each port uses a request/acknowledge handshake. The requester holds `req` high until it sees its `ack` pulse. The memory command sequencer sits behind the scheduler. For each slot it receives a one-clock start pulse together with the port number, the half index and a refresh flag.

Top module: `hub_slot_sched`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it rises, `gnt`, `ack`, `mem_go` and `mem_ref` are all 0 and `hub_slot` is 0.
- R2: Slots alternate between the first slot (`hub_slot`=0) and the shared slot (`hub_slot`=1), each lasting `SLOT_LEN` clocks. At most one start is issued per slot. `mem_go` and `gnt` (one-hot, bit i = port i) are high only in the second clock of a slot, for exactly one clock.
- R3: In dedicated mode (`mode`=0), only port 0 is ever started in the first slot, and it is started whenever it is requesting.
- R4: In priority mode (`mode`=1), port 0 wins the first slot whenever it is requesting. Otherwise the round-robin choice among ports 1..N-1 gets that slot.
- R5: The round-robin choice searches from the port after the last shared port that was granted, wrapping from N-1 back to 1. The search starts at port 1 after reset. The pointer moves only when a shared port is actually granted.
- R6: `ack` pulses for one clock, in the last clock of the slot that completes the access, and only on the bit of the port that owns that slot.
- R7: With `wide`=1 on its request, port 0 gets two starts: `mem_half`=0, then `mem_half`=1. The second half takes the shared slot if no other port is requesting and no refresh is forced; otherwise it takes the next first slot. Only the second half is acknowledged, so with no other traffic `ack[0]` comes 2·`SLOT_LEN`−2 clocks after the first `gnt[0]`.
- R8: Refresh (`mem_ref`=1 with `mem_go`) is issued only in the shared slot, never together with a grant. An unforced refresh is issued only when it is due, `blank`=1, no shared port is requesting and no wide second half is waiting.
- R9: Once `REF_PERIOD`+`REF_MAX_WAIT` clocks have passed since the last refresh decision, the next shared slot carries a refresh whatever `blank` and the requests are.
- R10: A refresh is due once `REF_PERIOD` clocks have passed since the last refresh decision, or since reset. With `blank` held high and no requests, consecutive refreshes are exactly `REF_PERIOD` clocks apart when `REF_PERIOD` is a multiple of 2·`SLOT_LEN`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | 0 = first slot reserved for port 0, 1 = first slot falls back to rotation |
| blank | input | 1 | High during display blanking; opens the shared slot to refresh |
| req | input | NPORT | Per-port request, held until the matching ack |
| wide | input | 1 | Port 0 asks for a 32-bit (two-slot) access; held with req[0] |
| gnt | output | NPORT | One-clock one-hot grant at slot start |
| ack | output | NPORT | One-clock completion pulse |
| mem_go | output | 1 | One-clock start of a memory slot operation |
| mem_ref | output | 1 | The started operation is a refresh |
| mem_port | output | $clog2(NPORT) | Port served by the started operation |
| mem_half | output | 1 | 0 = low/only half, 1 = second half of a wide access |
| hub_slot | output | 1 | Current slot index within the hub cycle |

## Verification
The bench goes after the boundary where a wide access meets competing traffic or a forced refresh. A design that handles this wrongly would acknowledge port 0 after its first half, or would let the second half take the shared slot from a waiting port. It also checks rotation fairness when every shared port requests at once, where a pointer that moved on idle slots would skip a port. Refresh spacing is measured with blanking held open and with blanking held closed. An off-by-one in the elapsed-clock counter would move the refresh a whole hub cycle, and a missing forced path would never refresh at all. Mode changes in the middle of a run check that the first slot stays idle in dedicated mode rather than leaking to the rotation.

// File: rtl/hss_pkg.sv
package hss_pkg;
   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_PORT = 2'd1,
      OWN_REF  = 2'd2
   } own_kind_e;
endpackage

// File: rtl/hss_slot_timer.sv
module hss_slot_timer #(
   parameter int SLOT_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic slot_start,
   output logic ack_tick,
   output logic slot_sel
);
   localparam int CW = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt      <= '0;
         slot_sel <= 1'b0;
      end else if (cnt == CW'(SLOT_LEN - 1)) begin
         cnt      <= '0;
         slot_sel <= ~slot_sel;
      end else begin
         cnt <= cnt + CW'(1);
      end
   end

   assign slot_start = (cnt == '0);
   assign ack_tick   = (cnt == CW'(SLOT_LEN - 2));

   assert_slot_start_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
      slot_start |=> !slot_start);
   assert_slot_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_sel != $past(slot_sel)) |-> slot_start);
endmodule

// File: rtl/hss_rr_pick.sv
module hss_rr_pick #(
   parameter int NSH = 7,
   parameter int SW  = 3
) (
   input  logic [NSH-1:0] req_sh,
   input  logic [SW-1:0]  last,
   output logic           found,
   output logic [SW-1:0]  pick
);
   always_comb begin
      found = 1'b0;
      pick  = last;
      for (int k = 1; k <= NSH; k++) begin
         int idx;
         idx = (int'(last) + k) % NSH;
         if (!found && req_sh[idx]) begin
            found = 1'b1;
            pick  = SW'(idx);
         end
      end
   end
endmodule

// File: rtl/hss_ref_timer.sv
module hss_ref_timer #(
   parameter int REF_PERIOD   = 64,
   parameter int REF_MAX_WAIT = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic due,
   output logic force_now
);
   localparam int LIM = REF_PERIOD + REF_MAX_WAIT;
   localparam int EW  = $clog2(LIM + 1);

   logic [EW-1:0] elapsed;

   always_ff @(posedge clk) begin
      if (!rst_n)
         elapsed <= '0;
      else if (restart)
         elapsed <= EW'(1);
      else if (elapsed != EW'(LIM))
         elapsed <= elapsed + EW'(1);
   end

   assign due       = (elapsed >= EW'(REF_PERIOD));
   assign force_now = (elapsed >= EW'(LIM));

   assert_restart_clears_due_R10: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !due);
endmodule

// File: rtl/hub_slot_sched.sv
module hub_slot_sched #(
   parameter int NPORT        = 8,
   parameter int SLOT_LEN     = 4,
   parameter int REF_PERIOD   = 64,
   parameter int REF_MAX_WAIT = 48
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mode,
   input  logic                     blank,
   input  logic [NPORT-1:0]         req,
   input  logic                     wide,
   output logic [NPORT-1:0]         gnt,
   output logic [NPORT-1:0]         ack,
   output logic                     mem_go,
   output logic                     mem_ref,
   output logic [$clog2(NPORT)-1:0] mem_port,
   output logic                     mem_half,
   output logic                     hub_slot
);
   import hss_pkg::*;

   localparam int PW  = $clog2(NPORT);
   localparam int NSH = NPORT - 1;
   localparam int SW  = (NSH > 1) ? $clog2(NSH) : 1;

   if (NPORT < 3) begin : g_bad_nport
      $error("NPORT must be at least 3");
   end
   if (SLOT_LEN < 3) begin : g_bad_slot
      $error("SLOT_LEN must be at least 3");
   end
   if (REF_PERIOD < 2) begin : g_bad_ref
      $error("REF_PERIOD must be at least 2");
   end

   logic slot_start, ack_tick, slot_sel;
   logic ref_due, ref_force, ref_restart;
   logic rr_found;
   logic [SW-1:0] rr_pick, rr_last;

   own_kind_e     d_kind;
   logic [PW-1:0] d_id;
   logic          d_half, d_done, d_adv;

   logic          gnt_v, own_v, ack_v, half_q;
   logic [PW-1:0] own_id, ack_id;

   hss_slot_timer #(.SLOT_LEN(SLOT_LEN)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .slot_start(slot_start), .ack_tick(ack_tick), .slot_sel(slot_sel)
   );

   hss_rr_pick #(.NSH(NSH), .SW(SW)) u_rr (
      .req_sh(req[NPORT-1:1]), .last(rr_last),
      .found(rr_found), .pick(rr_pick)
   );

   hss_ref_timer #(.REF_PERIOD(REF_PERIOD), .REF_MAX_WAIT(REF_MAX_WAIT)) u_ref (
      .clk(clk), .rst_n(rst_n), .restart(ref_restart),
      .due(ref_due), .force_now(ref_force)
   );

   wire sh_any = |req[NPORT-1:1];

   // slot policy: first slot favours port 0, shared slot ranks
   // forced refresh, wide tail, rotation, blanking refresh
   always_comb begin
      d_kind = OWN_IDLE;
      d_id   = '0;
      d_half = 1'b0;
      d_done = 1'b0;
      d_adv  = 1'b0;
      if (!slot_sel) begin
         if (half_q) begin
            d_kind = OWN_PORT; d_half = 1'b1; d_done = 1'b1;
         end else if (req[0]) begin
            d_kind = OWN_PORT; d_done = !wide;
         end else if (mode && rr_found) begin
            d_kind = OWN_PORT; d_id = PW'(rr_pick) + PW'(1);
            d_done = 1'b1; d_adv = 1'b1;
         end
      end else begin
         if (ref_force) begin
            d_kind = OWN_REF;
         end else if (half_q && !sh_any) begin
            d_kind = OWN_PORT; d_half = 1'b1; d_done = 1'b1;
         end else if (rr_found) begin
            d_kind = OWN_PORT; d_id = PW'(rr_pick) + PW'(1);
            d_done = 1'b1; d_adv = 1'b1;
         end else if (ref_due && blank) begin
            d_kind = OWN_REF;
         end
      end
   end

   assign ref_restart = slot_start && (d_kind == OWN_REF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gnt_v    <= 1'b0;
         mem_go   <= 1'b0;
         mem_ref  <= 1'b0;
         mem_port <= '0;
         mem_half <= 1'b0;
         own_v    <= 1'b0;
         own_id   <= '0;
         ack_v    <= 1'b0;
         ack_id   <= '0;
         half_q   <= 1'b0;
         rr_last  <= SW'(NSH - 1);
      end else begin
         gnt_v   <= 1'b0;
         mem_go  <= 1'b0;
         mem_ref <= 1'b0;
         ack_v   <= 1'b0;
         if (slot_start) begin
            gnt_v    <= (d_kind == OWN_PORT);
            mem_go   <= (d_kind != OWN_IDLE);
            mem_ref  <= (d_kind == OWN_REF);
            mem_port <= d_id;
            mem_half <= d_half;
            own_v    <= (d_kind == OWN_PORT) && d_done;
            own_id   <= d_id;
            if (d_kind == OWN_PORT && d_id == '0)
               half_q <= !d_done;
            if (d_adv)
               rr_last <= rr_pick;
         end
         if (ack_tick) begin
            ack_v  <= own_v;
            ack_id <= own_id;
            own_v  <= 1'b0;
         end
      end
   end

   for (genvar i = 0; i < NPORT; i++) begin : g_port
      assign gnt[i] = gnt_v && (mem_port == PW'(i));
      assign ack[i] = ack_v && (ack_id == PW'(i));
   end

   assign hub_slot = slot_sel;

   assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));
   assert_gnt_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_go |=> !mem_go);
   assert_dedicated_slot0_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_go && !hub_slot && !$past(mode)) |-> gnt[0]);
   assert_priv_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt_v && !hub_slot && mem_port != '0) |-> !$past(req[0]));
   assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|ack) |=> (ack == '0));
   assert_ref_shared_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ref |-> (hub_slot && gnt == '0));
endmodule

// File: tb/sim_hub_slot_sched.sv
module sim_hub_slot_sched;
   localparam int CLK_PERIOD = 10;
   localparam int N   = 8;
   localparam int L   = 4;
   localparam int RP  = 64;
   localparam int RW  = 48;
   localparam int LIM = RP + RW;
   localparam int PW  = $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode = 1'b0;
   logic blank = 1'b0;
   logic wide = 1'b0;
   logic [N-1:0] req = '0;
   logic [N-1:0] gnt, ack;
   logic mem_go, mem_ref, mem_half, hub_slot;
   logic [PW-1:0] mem_port;

   int nchk = 0;
   int nfail = 0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hub_slot_sched #(.NPORT(N), .SLOT_LEN(L), .REF_PERIOD(RP), .REF_MAX_WAIT(RW)) u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .blank(blank), .req(req), .wide(wide),
      .gnt(gnt), .ack(ack), .mem_go(mem_go), .mem_ref(mem_ref),
      .mem_port(mem_port), .mem_half(mem_half), .hub_slot(hub_slot)
   );

   // reference model built from the requirements
   int m_cnt, m_slot, m_el, m_last, m_half, m_ownv, m_ownid;
   int e_go, e_ref, e_gv, e_id, e_hf, e_ackv, e_ackid, e_forced;

   always @(posedge clk) begin
      int kind, id, hf, done, adv, p, found, shany;
      if (!rst_n) begin
         m_cnt = 0; m_slot = 0; m_el = 0; m_last = N-1; m_half = 0;
         m_ownv = 0; m_ownid = 0;
         e_go = 0; e_ref = 0; e_gv = 0; e_id = 0; e_hf = 0;
         e_ackv = 0; e_ackid = 0; e_forced = 0;
      end else begin
         e_go = 0; e_ref = 0; e_gv = 0; e_ackv = 0;
         kind = 0; id = 0; hf = 0; done = 0; adv = 0;
         found = 0; p = 0;
         shany = (req[N-1:1] != '0);
         for (int k = 1; k < N; k++) begin
            int q;
            q = ((m_last - 1 + k) % (N-1)) + 1;
            if (!found && req[q]) begin found = 1; p = q; end
         end
         if (m_cnt == 0) begin
            if (m_slot == 0) begin
               if (m_half) begin kind = 1; hf = 1; done = 1; end
               else if (req[0]) begin kind = 1; done = !wide; end
               else if (mode && found) begin kind = 1; id = p; done = 1; adv = 1; end
            end else begin
               if (m_el >= LIM) kind = 2;
               else if (m_half && !shany) begin kind = 1; hf = 1; done = 1; end
               else if (found) begin kind = 1; id = p; done = 1; adv = 1; end
               else if (m_el >= RP && blank) kind = 2;
            end
            e_forced = (kind == 2) && !blank;
            e_go = (kind != 0); e_ref = (kind == 2); e_gv = (kind == 1);
            e_id = id; e_hf = hf;
            m_ownv = (kind == 1) && done; m_ownid = id;
            if (kind == 1 && id == 0) m_half = !done;
            if (adv) m_last = p;
         end
         if (m_cnt == L-2) begin
            e_ackv = m_ownv; e_ackid = m_ownid; m_ownv = 0;
         end
         if (m_cnt == 0 && kind == 2) m_el = 1;
         else if (m_el < LIM) m_el = m_el + 1;
         if (m_cnt == L-1) begin m_cnt = 0; m_slot = 1 - m_slot; end
         else m_cnt = m_cnt + 1;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic compare();
      logic [N-1:0] eg, ea;
      eg = e_gv ? (N'(1) << e_id) : '0;
      ea = e_ackv ? (N'(1) << e_ackid) : '0;
      chk("R2 slot index", 32'(hub_slot), 32'(m_slot));
      if (m_slot == 0)
         chk(mode ? "R4 first-slot grant" : "R3 first-slot grant", 32'(gnt), 32'(eg));
      else
         chk("R5 shared-slot grant", 32'(gnt), 32'(eg));
      chk("R6 ack", 32'(ack), 32'(ea));
      chk(e_forced ? "R9 forced refresh" : "R8 refresh", 32'({mem_go, mem_ref}), 32'({e_go[0], e_ref[0]}));
      if (e_go != 0 && e_ref == 0) begin
         chk("R5 served port", 32'(mem_port), 32'(e_id));
         chk("R7 half index", 32'(mem_half), 32'(e_hf));
      end
   endtask

   task automatic step(input int r0, input int rs);
      @(negedge clk);
      cyc++;
      compare();
      for (int i = 0; i < N; i++) begin
         if (req[i] && ack[i]) req[i] = 1'b0;
         else if (!req[i]) begin
            if (int'($urandom % 100) < ((i == 0) ? r0 : rs)) begin
               req[i] = 1'b1;
               if (i == 0) wide = $urandom % 2;
            end
         end
      end
   endtask

   task automatic drain();
      for (int i = 0; i < 200 && req != '0; i++) step(0, 0);
   endtask

   task automatic run(input int n, input int r0, input int rs);
      for (int i = 0; i < n; i++) begin
         if (i % 97 == 0) blank = (int'($urandom % 100) < 35);
         step(r0, rs);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      nchk++; nfail++;
      $display("FAIL R2 watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      int t1, t2, t3, tg, ta;
      void'($urandom(32'd4711));
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", 32'({gnt, ack, mem_go, mem_ref, hub_slot}), 32'(0));
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      chk("R1 first clock after reset", 32'({gnt, ack, mem_go, mem_ref, hub_slot}), 32'(0));

      mode = 1'b0; run(3000, 25, 15);
      mode = 1'b1; run(3000, 25, 15);
      mode = 1'b1; run(2000, 4, 30);
      mode = 1'b0; run(2000, 60, 60);
      drain();

      // R10 refresh spacing with blanking open and no traffic
      blank = 1'b1; t1 = -1; t2 = -1; t3 = -1;
      for (int i = 0; i < 400 && t2 < 0; i++) begin
         step(0, 0);
         if (mem_ref) begin
            if (t1 < 0) t1 = cyc; else t2 = cyc;
         end
      end
      chk("R10 refresh spacing", 32'(t2 - t1), 32'(RP));
      // R9 forced refresh with blanking closed
      blank = 1'b0;
      for (int i = 0; i < 400 && t3 < 0; i++) begin
         step(0, 0);
         if (mem_ref) t3 = cyc;
      end
      chk("R9 forced refresh spacing", 32'(t3 - t2), 32'(LIM));

      // R7 wide access by port 0 with no other traffic
      req[0] = 1'b1; wide = 1'b1; tg = -1; ta = -1;
      for (int i = 0; i < 100 && ta < 0; i++) begin
         step(0, 0);
         if (gnt[0] && !mem_half && tg < 0) tg = cyc;
         if (ack[0]) ta = cyc;
      end
      chk("R7 wide latency", 32'(ta - tg), 32'(2*L - 2));
      drain();

      // R5 rotation under full load, then mixed
      mode = 1'b0; blank = 1'b0; run(600, 0, 100);
      mode = 1'b1; run(600, 50, 100);
      drain();

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule